// File: doc/BRIEF.md
# Reset Sequencer and Non-Maskable Fault Controller

This block sits beside a small processor core and owns two things the core cannot mask: reset and fault interrupts. While the active-low reset pin is low, it holds the core and clears every fault record. When the pin goes high, it keeps the core held for a fixed number of clock cycles so the oscillator can settle. It then releases the core with a one-cycle start strobe and the fixed start address.

Once the core runs, three fault sources feed a sticky cause register with one bit per source. The sources are an active-low external pin, a watchdog overflow pulse qualified by the watchdog's count-enable bit, and a vector of fatal-error pulses from the core, such as a misaligned access or an undefined opcode. Any recorded cause raises a request to the core, together with the fixed handler address. The core's interrupt-enable bit and its three-bit mask level have no say in this. The handler reads the cause register and clears the bits it has dealt with by writing ones. It acknowledges the request on entry, so a fresh request is only raised after it has written the register.

Top module: `rstnmi_ctrl`

## Requirements
- R1: When `rst_pin_n` is sampled low at a rising edge, then after that edge `core_hold` is 1, `nmi_cause` is 0 and `nmi_req` is 0. Fault inputs have no effect while `core_hold` is 1.
- R2: After `rst_pin_n` is sampled high at STAB_CYC consecutive edges, `core_hold` falls after the last of those edges and `boot_go` is 1 for exactly that one cycle. `boot_addr` is 0x40000000.
- R3: If `rst_pin_n` is sampled low during the wait, the wait starts again from zero. A full STAB_CYC high edges are then needed again.
- R4: Once any cause bit is set and no request is outstanding, `nmi_req` is 1, whatever `core_ie` and `core_im` are. `nmi_vec` is 0x40000008.
- R5: `nmi_pin_n` sampled low sets cause bit 0 after that edge.
- R6: `wdt_ovf` sets cause bit 1 only when `wdt_cnt_en` is 1 at the same edge. Otherwise the pulse is ignored.
- R7: Any bit of `err_in` sampled high sets cause bit 2.
- R8: Cause bits are sticky. A write (`cause_wr`=1) clears each bit whose `cause_wdata` bit is 1 and leaves the others alone. A new event for a bit in the same cycle as its clear leaves that bit set.
- R9: `nmi_req` stays 1 until `nmi_ack` is sampled high. It then stays 0 until the next cause write. After that write it is 1 again if any cause bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Reset pin, active low, sampled synchronously |
| nmi_pin_n | input | 1 | External fault pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_cnt_en | input | 1 | Watchdog count-enable control bit |
| err_in | input | NERR | Fatal-error pulses from the core |
| core_ie | input | 1 | Core interrupt-enable bit (ignored by design) |
| core_im | input | 3 | Core interrupt mask level (ignored by design) |
| cause_wr | input | 1 | Cause register write strobe |
| cause_wdata | input | 3 | Write-one-to-clear data |
| nmi_ack | input | 1 | Core accepted the request |
| nmi_cause | output | 3 | Cause register: bit0 pin, bit1 watchdog, bit2 system error |
| nmi_req | output | 1 | Non-maskable request to the core |
| nmi_vec | output | 32 | Handler address |
| core_hold | output | 1 | Keep core in reset |
| boot_go | output | 1 | One-cycle start strobe |
| boot_addr | output | 32 | Start address |

## Verification
The assertions assume that every input is synchronous to `clk`, so a pin level seen at an edge is the level the design acts on. They also assume that `nmi_ack` is only meaningful while `nmi_req` is high. The stimulus changes inputs only on falling edges and raises the acknowledge only while a request is visible. It drives fault inputs during the reset wait only to show that they are dropped.

// File: rtl/rstnmi_pkg.sv
package rstnmi_pkg;

    localparam int NSRC = 3;

    typedef logic [NSRC-1:0] cause_t;

    // Bit positions are fixed: software decodes them.
    typedef struct packed {
        logic sys;   // bit 2
        logic wdt;   // bit 1
        logic ext;   // bit 0
    } fault_ev_t;

    typedef enum logic {
        BT_HOLD = 1'b0,
        BT_RUN  = 1'b1
    } boot_st_e;

    localparam logic [31:0] RESET_VEC_DEF = 32'h4000_0000;
    localparam logic [31:0] NMI_VEC_DEF   = 32'h4000_0008;

    // Clear first, then set: a same-cycle event survives its clear.
    function automatic cause_t cause_next(cause_t cur, cause_t clr, cause_t set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/rstnmi_boot.sv
module rstnmi_boot
    import rstnmi_pkg::*;
#(
    parameter int STAB_CYC = 64
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic hold,
    output logic go
);
    localparam int CW = (STAB_CYC < 2) ? 1 : $clog2(STAB_CYC);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

    boot_st_e      st_q;
    logic [CW-1:0] cnt_q;
    logic          go_q;

    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            st_q  <= BT_HOLD;
            cnt_q <= '0;
            go_q  <= 1'b0;
        end else if (st_q == BT_HOLD) begin
            if (cnt_q == LAST) begin
                st_q  <= BT_RUN;
                cnt_q <= '0;
                go_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                go_q  <= 1'b0;
            end
        end else begin
            go_q <= 1'b0;
        end
    end

    assign hold = (st_q == BT_HOLD);
    assign go   = go_q;

    // R1: a low pin always puts the core on hold
    assert_pin_holds_R1: assert property (@(posedge clk) !rst_pin_n |=> hold);

    // R3: a low pin restarts the wait from zero
    assert_wait_restart_R3: assert property (@(posedge clk) !rst_pin_n |=> (cnt_q == '0));

    // R2: release is accompanied by the start strobe, which lasts one cycle
    assert_release_strobe_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(hold) |-> go);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
        go |=> !go);

endmodule

// File: rtl/rstnmi_cause.sv
module rstnmi_cause
    import rstnmi_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t set_ev,
    input  cause_t clr,
    output cause_t cause
);
    cause_t cause_q;

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= cause_next(cause_q, clr, set_ev);
    end

    assign cause = cause_q;

    // R8: an event leaves its bit set, even against a clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst !== 1'b0)
        (set_ev != '0) |=> ((cause & $past(set_ev)) == $past(set_ev)));

    // R8: a cleared bit with no competing event reads zero
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst !== 1'b0)
        ((clr & ~set_ev) != '0) |=> ((cause & $past(clr & ~set_ev)) == '0));

    // R8: without a clear nothing drops
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst !== 1'b0)
        (clr == '0) |=> ((cause & $past(cause)) == $past(cause)));

endmodule

// File: rtl/rstnmi_req.sv
module rstnmi_req (
    input  logic clk,
    input  logic rst,
    input  logic any_cause,
    input  logic wr,
    input  logic ack,
    output logic req
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)            busy_q <= 1'b0;
        else if (wr)        busy_q <= 1'b0;
        else if (ack && req) busy_q <= 1'b1;
    end

    assign req = any_cause && !busy_q;

    // R9: acknowledgement drops the request until a write
    assert_ack_drops_R9: assert property (@(posedge clk) disable iff (rst !== 1'b0)
        (ack && req && !wr) |=> !req);

    // R9: an unacknowledged request stays up
    assert_req_holds_R9: assert property (@(posedge clk) disable iff (rst !== 1'b0)
        (req && !ack && !wr) |=> req);

endmodule

// File: rtl/rstnmi_ctrl.sv
module rstnmi_ctrl
    import rstnmi_pkg::*;
#(
    parameter int          STAB_CYC  = 64,
    parameter int          NERR      = 3,
    parameter logic [31:0] RESET_VEC = RESET_VEC_DEF,
    parameter logic [31:0] NMI_VEC   = NMI_VEC_DEF
) (
    input  logic            clk,
    input  logic            rst_pin_n,
    input  logic            nmi_pin_n,
    input  logic            wdt_ovf,
    input  logic            wdt_cnt_en,
    input  logic [NERR-1:0] err_in,
    input  logic            core_ie,
    input  logic [2:0]      core_im,
    input  logic            cause_wr,
    input  logic [2:0]      cause_wdata,
    input  logic            nmi_ack,
    output logic [2:0]      nmi_cause,
    output logic            nmi_req,
    output logic [31:0]     nmi_vec,
    output logic            core_hold,
    output logic            boot_go,
    output logic [31:0]     boot_addr
);
    logic      hold;
    logic      rst_i;
    fault_ev_t ev;
    cause_t    clr;
    cause_t    cause;

    rstnmi_boot #(.STAB_CYC(STAB_CYC)) u_boot (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .hold      (hold),
        .go        (boot_go)
    );

    // Reset outranks everything: the pin acts at once, the wait keeps it.
    assign rst_i = hold || !rst_pin_n;

    always_comb begin
        ev.ext = !nmi_pin_n;
        ev.wdt = wdt_ovf && wdt_cnt_en;
        ev.sys = |err_in;
    end

    assign clr = cause_wr ? cause_t'(cause_wdata) : '0;

    rstnmi_cause u_cause (
        .clk    (clk),
        .rst    (rst_i),
        .set_ev (cause_t'(ev)),
        .clr    (clr),
        .cause  (cause)
    );

    rstnmi_req u_req (
        .clk       (clk),
        .rst       (rst_i),
        .any_cause (|cause),
        .wr        (cause_wr),
        .ack       (nmi_ack),
        .req       (nmi_req)
    );

    assign nmi_cause = cause;
    assign nmi_vec   = NMI_VEC;
    assign core_hold = hold;
    assign boot_addr = RESET_VEC;

    // R4: a new cause raises the request even with interrupts masked
    assert_unmaskable_R4: assert property (@(posedge clk) disable iff (rst_i !== 1'b0)
        ($rose(|nmi_cause) && (!core_ie || core_im == 3'd0 || core_im != 3'd0)) |-> nmi_req);

    // R5: pin low records bit 0
    assert_pin_cause_R5: assert property (@(posedge clk) disable iff (rst_i !== 1'b0)
        !nmi_pin_n |=> nmi_cause[0]);

    // R6: an overflow without count enable leaves bit 1 alone
    assert_wdt_gate_R6: assert property (@(posedge clk) disable iff (rst_i !== 1'b0)
        (!wdt_cnt_en && !nmi_cause[1]) |=> !nmi_cause[1]);

    // R7: any error pulse records bit 2
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst_i !== 1'b0)
        (|err_in) |=> nmi_cause[2]);

endmodule

// File: tb/sim_rstnmi_ctrl.sv
module sim_rstnmi_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int STAB       = 8;
    localparam int NERR       = 3;

    logic            clk = 1'b0;
    logic            rst_pin_n = 1'b0;
    logic            nmi_pin_n = 1'b1;
    logic            wdt_ovf = 1'b0;
    logic            wdt_cnt_en = 1'b0;
    logic [NERR-1:0] err_in = '0;
    logic            core_ie = 1'b0;
    logic [2:0]      core_im = 3'd7;
    logic            cause_wr = 1'b0;
    logic [2:0]      cause_wdata = '0;
    logic            nmi_ack = 1'b0;
    logic [2:0]      nmi_cause;
    logic            nmi_req;
    logic [31:0]     nmi_vec;
    logic            core_hold;
    logic            boot_go;
    logic [31:0]     boot_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstnmi_ctrl #(.STAB_CYC(STAB), .NERR(NERR)) u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .nmi_pin_n(nmi_pin_n),
        .wdt_ovf(wdt_ovf), .wdt_cnt_en(wdt_cnt_en), .err_in(err_in),
        .core_ie(core_ie), .core_im(core_im), .cause_wr(cause_wr),
        .cause_wdata(cause_wdata), .nmi_ack(nmi_ack), .nmi_cause(nmi_cause),
        .nmi_req(nmi_req), .nmi_vec(nmi_vec), .core_hold(core_hold),
        .boot_go(boot_go), .boot_addr(boot_addr)
    );

    typedef struct {
        string      tag;
        logic [2:0] cause;
        logic       req;
        logic       hold;
        logic       go;
    } exp_t;

    exp_t sb[$];

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: let one edge pass, then queue what must be seen after it.
    task automatic tick(input logic [2:0] c, input logic r, input logic h, input logic g, input string tag);
        exp_t e;
        @(posedge clk);
        e.tag = tag; e.cause = c; e.req = r; e.hold = h; e.go = g;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare at the falling edge after each queued edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "nmi_cause", 32'(nmi_cause), 32'(e.cause));
                cmp(e.tag, "nmi_req",   32'(nmi_req),   32'(e.req));
                cmp(e.tag, "core_hold", 32'(core_hold), 32'(e.hold));
                cmp(e.tag, "boot_go",   32'(boot_go),   32'(e.go));
                if (e.go) cmp("R2", "boot_addr", boot_addr, 32'h4000_0000);
                if (e.req) cmp("R4", "nmi_vec", nmi_vec, 32'h4000_0008);
            end
        end
    end

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        // R1: pin low from time zero
        @(negedge clk);
        tick(3'b000, 0, 1, 0, "R1 reset");
        tick(3'b000, 0, 1, 0, "R1 reset");

        // R2: release after STAB high edges
        rst_pin_n = 1'b1;
        for (int k = 1; k < STAB; k++) tick(3'b000, 0, 1, 0, "R2 wait");
        tick(3'b000, 0, 0, 1, "R2 release");
        tick(3'b000, 0, 0, 0, "R2 strobe single");

        // R5 and R4 with interrupts masked
        core_ie = 1'b0; core_im = 3'd7;
        nmi_pin_n = 1'b0;
        tick(3'b001, 1, 0, 0, "R5 R4 pin");
        nmi_pin_n = 1'b1;
        tick(3'b001, 1, 0, 0, "R8 sticky");
        nmi_ack = 1'b1;
        tick(3'b001, 0, 0, 0, "R9 ack");
        nmi_ack = 1'b0;
        tick(3'b001, 0, 0, 0, "R9 quiet after ack");
        cause_wr = 1'b1; cause_wdata = 3'b001;
        tick(3'b000, 0, 0, 0, "R8 clear");
        cause_wr = 1'b0; cause_wdata = 3'b000;

        // R6: watchdog gate
        wdt_ovf = 1'b1; wdt_cnt_en = 1'b0;
        tick(3'b000, 0, 0, 0, "R6 gated off");
        wdt_cnt_en = 1'b1;
        tick(3'b010, 1, 0, 0, "R6 enabled");
        wdt_ovf = 1'b0;

        // R7: each error bit
        err_in = 3'b001;
        tick(3'b110, 1, 0, 0, "R7 misalign");
        err_in = 3'b100;
        tick(3'b110, 1, 0, 0, "R7 other");

        // R8: set beats clear, then clear one bit only
        err_in = 3'b010; cause_wr = 1'b1; cause_wdata = 3'b100;
        tick(3'b110, 1, 0, 0, "R8 set wins");
        err_in = 3'b000;
        tick(3'b010, 1, 0, 0, "R8 clear bit2");
        cause_wdata = 3'b010;
        tick(3'b000, 0, 0, 0, "R8 clear bit1");
        cause_wr = 1'b0; cause_wdata = 3'b000;

        // R9: no re-issue until a write, then re-issue
        core_ie = 1'b1; core_im = 3'd0;
        nmi_pin_n = 1'b0;
        tick(3'b001, 1, 0, 0, "R5 pin again");
        nmi_pin_n = 1'b1; nmi_ack = 1'b1;
        tick(3'b001, 0, 0, 0, "R9 ack");
        nmi_ack = 1'b0; wdt_ovf = 1'b1;
        tick(3'b011, 0, 0, 0, "R9 no reissue");
        wdt_ovf = 1'b0; cause_wr = 1'b1; cause_wdata = 3'b001;
        tick(3'b010, 1, 0, 0, "R9 reissue");
        cause_wdata = 3'b010;
        tick(3'b000, 0, 0, 0, "R8 clear rest");
        cause_wr = 1'b0; cause_wdata = 3'b000;

        // R1: reset in operation clears causes
        err_in = 3'b001;
        tick(3'b100, 1, 0, 0, "R7 before reset");
        err_in = 3'b000; rst_pin_n = 1'b0;
        tick(3'b000, 0, 1, 0, "R1 clears");

        // R1 ignore during wait, R3 restart
        rst_pin_n = 1'b1; nmi_pin_n = 1'b0; wdt_ovf = 1'b1; wdt_cnt_en = 1'b1;
        for (int k = 0; k < 4; k++) tick(3'b000, 0, 1, 0, "R1 faults ignored");
        nmi_pin_n = 1'b1; wdt_ovf = 1'b0; rst_pin_n = 1'b0;
        tick(3'b000, 0, 1, 0, "R3 reassert");
        rst_pin_n = 1'b1;
        for (int k = 1; k < STAB; k++) tick(3'b000, 0, 1, 0, "R3 full wait");
        tick(3'b000, 0, 0, 1, "R3 release");
        tick(3'b000, 0, 0, 0, "R3 run");

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule